// File: doc/BRIEF.md
# Bidirectional Registered/Latched Bus Transfer Cell

This block moves an 18-bit word between two buses, called A and B, in either direction. Each direction has its own storage stage and its own four controls: a latch enable, a transfer clock, an active-low clock enable and an active-low output enable. While its latch enable is high, a direction is transparent and its output follows its source bus. While the latch enable is low, the stage keeps its value and loads a new word only on a rising edge of its transfer clock, and only while the clock enable is low. Both directions copy data without inversion.

The transfer clocks are ordinary data inputs that the system clock samples, so the design has a single clock domain. No real tri-state pads are used. Each driven side is shown as a data vector plus one drive-enable flag. A keeper register on each bus keeps the last value that was actually on that bus. The value on the bus can come from outside or from this block's own driver. When nothing outside drives an input bus, the transfer path reads the kept value.

Top module: `dualXferCell`

## Requirements
- R1: While `rstN` is low, `aOutEn` and `bOutEn` are 0 whatever the output enables are. After reset, both storage stages and both keepers hold all zeros.
- R2: When `leAb` is 1, `bOut` equals the A-side value in the same cycle, with no inversion. That value is `aIn` when `aInDrv` is 1.
- R3: When `leAb` is 0 and no qualified rising edge of `cpAb` is seen, `bOut` keeps its value, even while `cpAb` stays high and `aIn` changes.
- R4: When `leAb` is 0 and `ceAbN` is 0, the first system-clock edge that samples `cpAb` high, after a sample of `cpAb` low, loads the A-side value. `bOut` shows that value from that edge on.
- R5: While `ceAbN` is 1, a rising edge of `cpAb` loads nothing.
- R6: When `leAb` is 1 and a qualified `cpAb` edge happens at the same time, transparency wins and `bOut` keeps following the A side.
- R7: `bOutEn` is 1 exactly when `oeAbN` is 0 and the block is out of reset. `aOutEn` behaves the same way for `oeBaN`.
- R8: The B-to-A direction works like A-to-B but on its own. It uses `leBa`, `cpBa`, `ceBaN` and `oeBaN`, takes bus B as its source and drives `aOut`.
- R9: When `aInDrv` is 0, the A side takes the value bus A carried in the previous cycle, as held by the keeper. The same holds for `bInDrv` on the B side.
- R10: If the block itself drives bus A (`aOutEn` = 1) and no outside driver is present, the A keeper takes `aOut`. The kept value then survives after the drive is removed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| aIn | input | 18 | Value placed on bus A by an outside driver |
| aInDrv | input | 1 | 1 when an outside driver is active on bus A |
| bIn | input | 18 | Value placed on bus B by an outside driver |
| bInDrv | input | 1 | 1 when an outside driver is active on bus B |
| oeAbN | input | 1 | Active-low output enable, A-to-B |
| oeBaN | input | 1 | Active-low output enable, B-to-A |
| leAb | input | 1 | Latch enable (1 = transparent), A-to-B |
| leBa | input | 1 | Latch enable (1 = transparent), B-to-A |
| cpAb | input | 1 | Transfer clock, A-to-B, captures on a sampled rise |
| cpBa | input | 1 | Transfer clock, B-to-A, captures on a sampled rise |
| ceAbN | input | 1 | Active-low clock enable, A-to-B |
| ceBaN | input | 1 | Active-low clock enable, B-to-A |
| aOut | output | 18 | Data this block drives onto bus A |
| aOutEn | output | 1 | Drive enable for bus A |
| bOut | output | 18 | Data this block drives onto bus B |
| bOutEn | output | 1 | Drive enable for bus B |

## Verification
In the same cycle, a direction can see both a high latch enable and a qualified rising edge of its transfer clock. The bench causes this by raising `cpAb` while `leAb` is high. It then changes `aIn` during the cycles after the edge and expects `bOut` to follow the new values, not stay frozen at the word present at the edge. The second overlap is between the keeper and the block's own driver. The B-to-A output drives bus A while no outside driver is present, and the bench reads the kept value back through the transparent A-to-B path, both while the drive is on and after it is removed.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  // Per-direction strobes from control to datapath
  typedef struct packed {
    logic transparent;  // latch enable high: storage follows source
    logic capture;      // qualified rising transfer-clock edge
    logic drive;        // output drive permitted
  } xferStrobe_t;

  localparam int LANES = 2;  // lane 0: A->B, lane 1: B->A

endpackage

// File: rtl/xferCtrl.sv
module xferCtrl
  import xfer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        latchEn,
  input  logic        dirClk,
  input  logic        clkEnN,
  input  logic        outEnN,
  output xferStrobe_t strobe
);

  logic clkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) clkPrev <= 1'b0;
    else       clkPrev <= dirClk;
  end

  always_comb begin
    strobe.transparent = latchEn;
    strobe.capture     = !latchEn && !clkEnN && dirClk && !clkPrev;
    strobe.drive       = !outEnN && rstN;
  end

endmodule

// File: rtl/xferData.sv
module xferData
  import xfer_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [WIDTH-1:0]        aIn,
  input  logic                    aInDrv,
  input  logic [WIDTH-1:0]        bIn,
  input  logic                    bInDrv,
  input  xferStrobe_t [LANES-1:0] stb,
  output logic [WIDTH-1:0]        aOut,
  output logic                    aOutEn,
  output logic [WIDTH-1:0]        bOut,
  output logic                    bOutEn
);

  // bus index: 0 = A, 1 = B; lane g sources bus g and drives bus 1-g
  logic [LANES-1:0][WIDTH-1:0] busIn;
  logic [LANES-1:0]            busDrv;
  logic [LANES-1:0][WIDTH-1:0] keepQ;
  logic [LANES-1:0][WIDTH-1:0] seen;
  logic [LANES-1:0][WIDTH-1:0] storeQ;
  logic [LANES-1:0][WIDTH-1:0] laneOut;
  logic [LANES-1:0]            laneEn;

  assign busIn  = {bIn, aIn};
  assign busDrv = {bInDrv, aInDrv};

  for (genvar g = 0; g < LANES; g++) begin : gLane
    localparam int OTHER = LANES - 1 - g;

    // keeper of bus g: last value actually present on the bus
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              keepQ[g] <= '0;
      else if (busDrv[g])     keepQ[g] <= busIn[g];
      else if (laneEn[OTHER]) keepQ[g] <= laneOut[OTHER];
    end

    assign seen[g] = busDrv[g] ? busIn[g] : keepQ[g];

    // storage stage of lane g
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                       storeQ[g] <= '0;
      else if (stb[g].transparent || stb[g].capture)   storeQ[g] <= seen[g];
    end

    assign laneOut[g] = stb[g].transparent ? seen[g] : storeQ[g];
    assign laneEn[g]  = stb[g].drive;
  end

  assign bOut   = laneOut[0];
  assign bOutEn = laneEn[0];
  assign aOut   = laneOut[1];
  assign aOutEn = laneEn[1];

endmodule

// File: rtl/dualXferCell.sv
module dualXferCell
  import xfer_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] aIn,
  input  logic             aInDrv,
  input  logic [WIDTH-1:0] bIn,
  input  logic             bInDrv,
  input  logic             oeAbN,
  input  logic             oeBaN,
  input  logic             leAb,
  input  logic             leBa,
  input  logic             cpAb,
  input  logic             cpBa,
  input  logic             ceAbN,
  input  logic             ceBaN,
  output logic [WIDTH-1:0] aOut,
  output logic             aOutEn,
  output logic [WIDTH-1:0] bOut,
  output logic             bOutEn
);

  xferStrobe_t [LANES-1:0] stb;

  xferCtrl uCtrlAb (
    .clk(clk), .rstN(rstN), .latchEn(leAb), .dirClk(cpAb),
    .clkEnN(ceAbN), .outEnN(oeAbN), .strobe(stb[0])
  );

  xferCtrl uCtrlBa (
    .clk(clk), .rstN(rstN), .latchEn(leBa), .dirClk(cpBa),
    .clkEnN(ceBaN), .outEnN(oeBaN), .strobe(stb[1])
  );

  xferData #(.WIDTH(WIDTH)) uData (
    .clk(clk), .rstN(rstN),
    .aIn(aIn), .aInDrv(aInDrv), .bIn(bIn), .bInDrv(bInDrv),
    .stb(stb),
    .aOut(aOut), .aOutEn(aOutEn), .bOut(bOut), .bOutEn(bOutEn)
  );

endmodule

// File: rtl/dualXferCheck.sv
module dualXferCheck #(
  parameter int WIDTH = 18
) (
  input logic             clk,
  input logic             rstN,
  input logic [WIDTH-1:0] aIn,
  input logic             aInDrv,
  input logic [WIDTH-1:0] bIn,
  input logic             bInDrv,
  input logic             oeAbN,
  input logic             oeBaN,
  input logic             leAb,
  input logic             leBa,
  input logic             cpAb,
  input logic             cpBa,
  input logic             ceAbN,
  input logic             ceBaN,
  input logic [WIDTH-1:0] aOut,
  input logic             aOutEn,
  input logic [WIDTH-1:0] bOut,
  input logic             bOutEn
);

  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(rstN) && !leAb) |-> (bOut == '0));

  // R2
  transparent_ab_chk: assert property (@(posedge clk) disable iff (!rstN)
    (leAb && aInDrv) |-> (bOut == aIn));

  // R3
  hold_ab_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !leAb && !(cpAb && !$past(cpAb) && !ceAbN))
      |=> (leAb || bOut == $past(bOut)));

  // R4
  capture_ab_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !leAb && !ceAbN && cpAb && !$past(cpAb) && aInDrv)
      |=> (leAb || bOut == $past(aIn)));

  // R7
  drive_ab_chk: assert property (@(posedge clk) disable iff (!rstN)
    bOutEn == !oeAbN);

  // R8
  capture_ba_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !leBa && !ceBaN && cpBa && !$past(cpBa) && bInDrv)
      |=> (leBa || aOut == $past(bIn)));

  // R9
  keeper_ab_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(aInDrv) && !aInDrv && leAb) |-> (bOut == $past(aIn)));

endmodule

bind dualXferCell dualXferCheck #(.WIDTH(WIDTH)) uChk (.*);

// File: tb/tb_dualXferCell.sv
`timescale 1ns/1ps
module tb_dualXferCell;

  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] aIn = '0, bIn = '0;
  logic         aInDrv = 1'b0, bInDrv = 1'b0;
  logic         oeAbN = 1'b0, oeBaN = 1'b0;
  logic         leAb = 1'b0, leBa = 1'b0;
  logic         cpAb = 1'b0, cpBa = 1'b0;
  logic         ceAbN = 1'b1, ceBaN = 1'b1;
  logic [W-1:0] aOut, bOut;
  logic         aOutEn, bOutEn;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dualXferCell #(.WIDTH(W)) dut (.*);

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic nextNeg();
    @(negedge clk);
  endtask

  task automatic tReset();
    repeat (3) nextNeg();
    #1 chk("R1 aOutEn in reset", W'(aOutEn), W'(0));
    chk("R1 bOutEn in reset", W'(bOutEn), W'(0));
    rstN = 1'b1;
    #1 chk("R1 bOut zero after reset", bOut, '0);
    chk("R7 bOutEn after reset", W'(bOutEn), W'(1));
  endtask

  task automatic tTransparent();
    nextNeg();
    oeBaN = 1'b1; leAb = 1'b1; aInDrv = 1'b1; aIn = 18'h2A5C3;
    #1 chk("R2 follow 1", bOut, 18'h2A5C3);
    aIn = 18'h15A3C;
    #1 chk("R2 follow 2", bOut, 18'h15A3C);
  endtask

  task automatic tCapture();
    nextNeg();
    leAb = 1'b0; aIn = 18'h3FFFF;
    #1 chk("R3 hold after latch close", bOut, 18'h15A3C);
    nextNeg();
    #1 chk("R3 hold no edge", bOut, 18'h15A3C);
    ceAbN = 1'b0; cpAb = 1'b1; aIn = 18'h0F0F0;
    nextNeg();
    #1 chk("R4 capture on rise", bOut, 18'h0F0F0);
    aIn = 18'h11111;
    nextNeg();
    #1 chk("R3 clock held high", bOut, 18'h0F0F0);
    cpAb = 1'b0;
    nextNeg();
    cpAb = 1'b1; aIn = 18'h22222;
    nextNeg();
    #1 chk("R4 second capture", bOut, 18'h22222);
  endtask

  task automatic tClockEnable();
    cpAb = 1'b0; ceAbN = 1'b1;
    nextNeg();
    cpAb = 1'b1; aIn = 18'h33333;
    nextNeg();
    #1 chk("R5 gated edge ignored", bOut, 18'h22222);
    cpAb = 1'b0; ceAbN = 1'b0;
    nextNeg();
  endtask

  task automatic tPriority();
    leAb = 1'b1; cpAb = 1'b1; aIn = 18'h12345;
    #1 chk("R6 edge with latch open", bOut, 18'h12345);
    nextNeg();
    aIn = 18'h2BCDE;
    #1 chk("R6 still follows after edge", bOut, 18'h2BCDE);
    nextNeg();
    leAb = 1'b0; cpAb = 1'b0; aIn = '0;
    #1 chk("R6 latched last followed value", bOut, 18'h2BCDE);
  endtask

  task automatic tOutEnable();
    oeAbN = 1'b1;
    #1 chk("R7 released", W'(bOutEn), W'(0));
    oeAbN = 1'b0;
    #1 chk("R7 driven", W'(bOutEn), W'(1));
  endtask

  task automatic tReverse();
    nextNeg();
    bIn = 18'h0AAAA; bInDrv = 1'b1; leBa = 1'b1; oeBaN = 1'b0;
    #1 chk("R8 transparent B to A", aOut, 18'h0AAAA);
    chk("R8 aOutEn", W'(aOutEn), W'(1));
    chk("R7 both drivers on (contention seen)", W'(aOutEn & bOutEn), W'(1));
    nextNeg();
    leBa = 1'b0; ceBaN = 1'b0; cpBa = 1'b1; bIn = 18'h05555;
    nextNeg();
    #1 chk("R8 capture B to A", aOut, 18'h05555);
    bIn = 18'h3AAAA;
    nextNeg();
    #1 chk("R8 hold B to A", aOut, 18'h05555);
    cpBa = 1'b0; oeBaN = 1'b1;
  endtask

  task automatic tKeeper();
    aIn = 18'h1C0DE; aInDrv = 1'b1; leAb = 1'b1;
    nextNeg();
    aInDrv = 1'b0; aIn = 18'h3FFFF;
    #1 chk("R9 keeper after release", bOut, 18'h1C0DE);
    nextNeg();
    #1 chk("R9 keeper persists", bOut, 18'h1C0DE);
  endtask

  task automatic tKeeperOwn();
    leBa = 1'b1; oeBaN = 1'b0; bIn = 18'h07777; bInDrv = 1'b1;
    #1 chk("R10 own drive on A", aOut, 18'h07777);
    nextNeg();
    #1 chk("R10 keeper took own drive", bOut, 18'h07777);
    oeBaN = 1'b1; bIn = 18'h00001;
    nextNeg();
    #1 chk("R10 kept after release", bOut, 18'h07777);
  endtask

  initial begin
    tReset();
    tTransparent();
    tCapture();
    tClockEnable();
    tPriority();
    tOutEnable();
    tReverse();
    tKeeper();
    tKeeperOwn();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule